// File: doc/BRIEF.md
# Glitch-free GPIO bank state restore sequencer

This block keeps a copy of one GPIO bank's configuration, data and pull-up registers across a low-power period. When it sees the save strobe, it reads the three live registers through a read port with one cycle of latency and keeps them. When it sees the restore strobe, it writes the saved values back to the bank in an order that keeps every pin glitch-free.

Each pin has a 2-bit mode field in the configuration word. The encodings are 0 for input, 1 for output, and 2 or 3 for special function. Some pins should be reconfigured before new data reaches the data register, and others only after it. The block tells them apart by reading the bank's current configuration and comparing each pin's mode with its saved mode. From this comparison it builds a per-pin early mask.

It then writes four values to the bank over a simple write port with a ready input:

1. The saved pull-up value.
2. An early configuration word.
3. The saved data.
4. The full saved configuration.

**States.** The controller is a single state machine.

- `ST_IDLE` waits for a strobe.
- The save path is `ST_SV_CON` (read at 0x00), `ST_SV_DAT` (read at 0x04, capture configuration), `ST_SV_PUP` (read at 0x08, capture data) and `ST_SV_END` (capture pull-up, mark the snapshot valid).
- The restore path is `ST_RS_PUP` (write pull-up), `ST_RS_RDCON` (read the current configuration), `ST_RS_MASK` (form the early word), `ST_RS_EARLY`, `ST_RS_DAT` and `ST_RS_CON` (the three remaining writes).

**Transitions.**

- `ST_IDLE` goes to `ST_RS_PUP` on a restore strobe when a snapshot exists.
- `ST_IDLE` stays in `ST_IDLE` and sets the error flag on a restore strobe without a snapshot.
- `ST_IDLE` goes to `ST_SV_CON` on a save strobe. A restore strobe wins if both strobes arrive together.
- The save states advance every cycle and return to `ST_IDLE` after `ST_SV_END`.
- Each write state advances only when `wr_ready` is high.
- `ST_RS_RDCON` and `ST_RS_MASK` advance every cycle.
- `ST_RS_CON` returns to `ST_IDLE` and pulses done.

Top module: `gpio_restore_seq`

## Requirements
- R1: A save strobe reads addresses 0x00 (configuration), 0x04 (data) and 0x08 (pull-up), keeps all three, and issues no bank write.
- R2: Mode field encoding per pin (pin p at bits 2p+1:2p): 0 input, 1 output, 2 or 3 special function.
- R3: The first write of a restore goes to address 0x08 and carries the saved pull-up value.
- R4: A pin is kept out of the early mask when its mode is unchanged, when both the current and saved modes are special functions, or when the saved mode is output and the current mode is input or special function.
- R5: A pin is in the early mask for these transitions: input to special function, output to special function, output to input, and special function to input. Each mask field is either all ones or all zeros.
- R6: After the pull-up write there are exactly three more writes, in this order:
  - address 0x00: the current configuration with its masked fields replaced by the saved fields;
  - address 0x04: the saved data;
  - address 0x00: the saved configuration.
- R7: A write that is not yet accepted keeps wr_en, wr_addr and wr_data unchanged until wr_ready is high.
- R8: busy is high from the cycle after an accepted strobe until the last read or write of that operation completes, and it is low out of reset.
- R9: Save and restore strobes that arrive while busy are ignored. The running restore completes with its four writes and its original snapshot.
- R10: done is a single-cycle pulse in the cycle after the final configuration write is accepted.
- R11: A restore strobe before any completed save causes no write and no busy period. It sets err, and err stays high until a save completes.
- R12: The current configuration is read at 0x00 through the read port, and the value returned one cycle after rd_en is the value used for the early word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_req | input | 1 | Save strobe |
| restore_req | input | 1 | Restore strobe |
| rd_en | output | 1 | Bank read enable |
| rd_addr | output | ADDR_W | Bank read address |
| rd_data | input | DW | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Bank write request |
| wr_addr | output | ADDR_W | Bank write address |
| wr_data | output | DW | Bank write data |
| wr_ready | input | 1 | Bank accepts the write this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Restore completed pulse |
| err | output | 1 | Restore requested without a snapshot |

## Verification
The hardest case to reach is a single restore in which every pair of current and saved modes occurs at once. Write stalls and mid-sequence strobes must also happen in that same restore. A directed pattern reaches this: pin p has current mode p mod 4 and saved mode p div 4, so all sixteen pairs appear in one configuration word. Random wr_ready stalls and extra save and restore strobes issued while busy are added around it. Random bank contents from a fixed seed then cover the general mask and ordering.

// File: rtl/gpio_rs_pkg.sv
package gpio_rs_pkg;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_IN  = 2'd0;
    localparam logic [MODE_W-1:0] MODE_OUT = 2'd1;

    localparam int OFS_CFG = 0;
    localparam int OFS_DAT = 4;
    localparam int OFS_PUP = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SV_CON,
        ST_SV_DAT,
        ST_SV_PUP,
        ST_SV_END,
        ST_RS_PUP,
        ST_RS_RDCON,
        ST_RS_MASK,
        ST_RS_EARLY,
        ST_RS_DAT,
        ST_RS_CON
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_PUP,
        WK_EARLY,
        WK_DAT,
        WK_CFG
    } wr_kind_e;

    function automatic logic mode_is_sfn(input logic [MODE_W-1:0] m);
        return m[MODE_W-1];
    endfunction

endpackage

// File: rtl/gpio_rs_mask.sv
module gpio_rs_mask
    import gpio_rs_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int DW = NPINS * MODE_W
) (
    input  logic [DW-1:0] cur_cfg,
    input  logic [DW-1:0] saved_cfg,
    output logic [DW-1:0] early_mask
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [MODE_W-1:0] m_old;
        logic [MODE_W-1:0] m_new;
        logic              pick;

        assign m_old = cur_cfg[p*MODE_W +: MODE_W];
        assign m_new = saved_cfg[p*MODE_W +: MODE_W];

        always_comb begin
            if (m_old == m_new)                            pick = 1'b0;
            else if (mode_is_sfn(m_old) && mode_is_sfn(m_new)) pick = 1'b0;
            else if (m_new == MODE_OUT)                    pick = 1'b0;
            else                                           pick = 1'b1;
        end

        assign early_mask[p*MODE_W +: MODE_W] = {MODE_W{pick}};

        // R4
        always_comb begin
            if (m_old == m_new)
                unchanged_excl_chk: assert (early_mask[p*MODE_W +: MODE_W] == '0);
        end

        // R5
        always_comb begin
            mask_field_whole_chk: assert (early_mask[p*MODE_W +: MODE_W] == '0 ||
                                          early_mask[p*MODE_W +: MODE_W] == '1);
        end
    end

endmodule

// File: rtl/gpio_rs_snap.sv
module gpio_rs_snap
    import gpio_rs_pkg::*;
#(
    parameter int NPINS = 16,
    localparam int DW = NPINS * MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rd_data,
    input  logic          cap_cfg,
    input  logic          cap_dat,
    input  logic          cap_pup,
    output logic [DW-1:0] sv_cfg,
    output logic [DW-1:0] sv_dat,
    output logic [DW-1:0] sv_pup,
    output logic          sv_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_cfg   <= '0;
            sv_dat   <= '0;
            sv_pup   <= '0;
            sv_valid <= 1'b0;
        end else begin
            if (cap_cfg) sv_cfg <= rd_data;
            if (cap_dat) sv_dat <= rd_data;
            if (cap_pup) begin
                sv_pup   <= rd_data;
                sv_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_rs_fsm.sv
module gpio_rs_fsm
    import gpio_rs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic              snap_valid,
    input  logic              wr_ready,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output wr_kind_e          wr_kind,
    output logic              cap_cfg,
    output logic              cap_dat,
    output logic              cap_pup,
    output logic              cap_early,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
    localparam logic [ADDR_W-1:0] A_PUP = ADDR_W'(OFS_PUP);

    seq_state_e state;
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (restore_req)   nxt = snap_valid ? ST_RS_PUP : ST_IDLE;
                else if (save_req) nxt = ST_SV_CON;
            end
            ST_SV_CON:   nxt = ST_SV_DAT;
            ST_SV_DAT:   nxt = ST_SV_PUP;
            ST_SV_PUP:   nxt = ST_SV_END;
            ST_SV_END:   nxt = ST_IDLE;
            ST_RS_PUP:   if (wr_ready) nxt = ST_RS_RDCON;
            ST_RS_RDCON: nxt = ST_RS_MASK;
            ST_RS_MASK:  nxt = ST_RS_EARLY;
            ST_RS_EARLY: if (wr_ready) nxt = ST_RS_DAT;
            ST_RS_DAT:   if (wr_ready) nxt = ST_RS_CON;
            ST_RS_CON:   if (wr_ready) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_RS_CON) && wr_ready;
            if (state == ST_IDLE && restore_req && !snap_valid) err <= 1'b1;
            else if (state == ST_SV_END)                        err <= 1'b0;
        end
    end

    always_comb begin
        rd_en     = 1'b0;
        rd_addr   = A_CFG;
        wr_en     = 1'b0;
        wr_addr   = A_CFG;
        wr_kind   = WK_CFG;
        cap_cfg   = 1'b0;
        cap_dat   = 1'b0;
        cap_pup   = 1'b0;
        cap_early = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:     ;
            ST_SV_CON:   begin rd_en = 1'b1; rd_addr = A_CFG; end
            ST_SV_DAT:   begin rd_en = 1'b1; rd_addr = A_DAT; cap_cfg = 1'b1; end
            ST_SV_PUP:   begin rd_en = 1'b1; rd_addr = A_PUP; cap_dat = 1'b1; end
            ST_SV_END:   cap_pup = 1'b1;
            ST_RS_PUP:   begin wr_en = 1'b1; wr_addr = A_PUP; wr_kind = WK_PUP; end
            ST_RS_RDCON: begin rd_en = 1'b1; rd_addr = A_CFG; end
            ST_RS_MASK:  cap_early = 1'b1;
            ST_RS_EARLY: begin wr_en = 1'b1; wr_addr = A_CFG; wr_kind = WK_EARLY; end
            ST_RS_DAT:   begin wr_en = 1'b1; wr_addr = A_DAT; wr_kind = WK_DAT; end
            ST_RS_CON:   begin wr_en = 1'b1; wr_addr = A_CFG; wr_kind = WK_CFG; end
            default:     ;
        endcase
    end

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !wr_en);

    // R1
    save_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && save_req && !restore_req) |=> rd_en && !wr_en);

    // R11
    norestore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && restore_req && !snap_valid) |=> !busy && err);

    // R9
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en && !wr_ready) |=> busy);

endmodule

// File: rtl/gpio_restore_seq.sv
module gpio_restore_seq
    import gpio_rs_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 8,
    localparam int DW = NPINS * MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_req,
    input  logic              restore_req,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              err
);

    wr_kind_e      wr_kind;
    logic          cap_cfg, cap_dat, cap_pup, cap_early;
    logic [DW-1:0] sv_cfg, sv_dat, sv_pup;
    logic          sv_valid;
    logic [DW-1:0] early_mask;
    logic [DW-1:0] early_q;

    gpio_rs_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req),
        .snap_valid(sv_valid), .wr_ready(wr_ready),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_kind(wr_kind),
        .cap_cfg(cap_cfg), .cap_dat(cap_dat), .cap_pup(cap_pup),
        .cap_early(cap_early),
        .busy(busy), .done(done), .err(err)
    );

    gpio_rs_snap #(.NPINS(NPINS)) u_snap (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data),
        .cap_cfg(cap_cfg), .cap_dat(cap_dat), .cap_pup(cap_pup),
        .sv_cfg(sv_cfg), .sv_dat(sv_dat), .sv_pup(sv_pup),
        .sv_valid(sv_valid)
    );

    gpio_rs_mask #(.NPINS(NPINS)) u_mask (
        .cur_cfg(rd_data), .saved_cfg(sv_cfg), .early_mask(early_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         early_q <= '0;
        else if (cap_early) early_q <= (rd_data & ~early_mask) | (sv_cfg & early_mask);
    end

    always_comb begin
        unique case (wr_kind)
            WK_PUP:   wr_data = sv_pup;
            WK_EARLY: wr_data = early_q;
            WK_DAT:   wr_data = sv_dat;
            WK_CFG:   wr_data = sv_cfg;
            default:  wr_data = sv_cfg;
        endcase
    end

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> wr_en && $stable(wr_addr) && $stable(wr_data));

    // R3
    pup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && restore_req && sv_valid) |=> wr_en && wr_addr == ADDR_W'(OFS_PUP) && wr_data == sv_pup);

endmodule

// File: tb/gpio_restore_seq_tb.sv
module gpio_restore_seq_tb;

    localparam int NP = 16;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0;
    logic          restore_req = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          wr_ready = 1'b1;
    logic          busy, done, err;

    always #10 clk = ~clk;

    gpio_restore_seq #(.NPINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .busy(busy), .done(done), .err(err)
    );

    // bank model
    logic [DW-1:0] r_cfg = '0, r_dat = '0, r_pup = '0;
    logic          ld = 1'b0;
    logic [DW-1:0] ld_cfg = '0, ld_dat = '0, ld_pup = '0;
    logic          tr_clr = 1'b0;
    int            tr_n = 0;
    logic [AW-1:0] tr_addr [16];
    logic [DW-1:0] tr_data [16];
    int            done_cnt = 0;
    int            hold_bad = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [DW-1:0] pend_d = '0;
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en)
            rd_data <= (rd_addr == 8'd0) ? r_cfg : (rd_addr == 8'd4) ? r_dat : r_pup;
        if (ld) begin
            r_cfg <= ld_cfg; r_dat <= ld_dat; r_pup <= ld_pup;
        end else if (wr_en && wr_ready) begin
            if (wr_addr == 8'd0) r_cfg <= wr_data;
            else if (wr_addr == 8'd4) r_dat <= wr_data;
            else if (wr_addr == 8'd8) r_pup <= wr_data;
        end
        if (tr_clr) begin
            tr_n <= 0; done_cnt <= 0;
        end else begin
            if (wr_en && wr_ready && tr_n < 16) begin
                tr_addr[tr_n] <= wr_addr; tr_data[tr_n] <= wr_data; tr_n <= tr_n + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
        end
        if (pend && (!wr_en || wr_addr != pend_a || wr_data != pend_d)) hold_bad <= hold_bad + 1;
        pend <= wr_en && !wr_ready; pend_a <= wr_addr; pend_d <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_early(input logic [DW-1:0] cur, input logic [DW-1:0] sav);
        logic [DW-1:0] r = cur;
        for (int p = 0; p < NP; p++) begin
            logic [1:0] o = cur[2*p +: 2];
            logic [1:0] n = sav[2*p +: 2];
            if (n != o && n != 2'd1 && !(o >= 2'd2 && n >= 2'd2)) r[2*p +: 2] = n;
        end
        return r;
    endfunction

    task automatic preset(input logic [DW-1:0] c, input logic [DW-1:0] d, input logic [DW-1:0] u);
        @(negedge clk);
        ld = 1'b1; ld_cfg = c; ld_dat = d; ld_pup = u; tr_clr = 1'b1;
        @(negedge clk);
        ld = 1'b0; tr_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 400) begin
            @(negedge clk);
            wr_ready = ($urandom % 4) != 0;
            n++;
        end
        wr_ready = 1'b1;
        if (busy) chk(1'b0, "watchdog", 32'(busy), 32'd0);
    endtask

    task automatic do_save();
        @(negedge clk); save_req = 1'b1;
        @(negedge clk); save_req = 1'b0;
        chk(busy == 1'b1, "R8 busy after save", 32'(busy), 32'd1);
        wait_idle();
        @(negedge clk);
    endtask

    task automatic do_restore(input logic [DW-1:0] ac, input logic [DW-1:0] ad, input logic [DW-1:0] au,
                              input logic [DW-1:0] bc, input bit inject);
        logic [DW-1:0] ee;
        ee = exp_early(bc, ac);
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0;
        chk(busy == 1'b1, "R8 busy after restore", 32'(busy), 32'd1);
        if (inject) begin
            @(negedge clk); save_req = 1'b1;
            @(negedge clk); save_req = 1'b0; restore_req = 1'b1;
            @(negedge clk); restore_req = 1'b0;
        end
        wait_idle();
        @(negedge clk);
        chk(done_cnt == 1, "R10 one done pulse", 32'(done_cnt), 32'd1);
        chk(tr_n == 4, "R6/R9 write count", 32'(tr_n), 32'd4);
        if (tr_n == 4) begin
            chk(tr_addr[0] == 8'd8 && tr_data[0] == au, "R3 pull-up first", tr_data[0], au);
            chk(tr_addr[1] == 8'd0 && tr_data[1] == ee, "R4/R5/R12/R2 early config", tr_data[1], ee);
            chk(tr_addr[2] == 8'd4 && tr_data[2] == ad, "R6 data write", tr_data[2], ad);
            chk(tr_addr[3] == 8'd0 && tr_data[3] == ac, "R6 final config", tr_data[3], ac);
        end
        chk(r_cfg == ac && r_dat == ad && r_pup == au, "R9 bank restored", r_cfg, ac);
        chk(hold_bad == 0, "R7 write hold", 32'(hold_bad), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !wr_en, "R8 reset state", {busy, done, err, wr_en}, 32'd0);

        // restore before any save
        preset(32'h1234_5678, 32'h0, 32'h0);
        @(negedge clk); restore_req = 1'b1;
        @(negedge clk); restore_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R11 err set", 32'(err), 32'd1);
        chk(busy == 1'b0 && tr_n == 0, "R11 no writes", 32'(tr_n), 32'd0);

        for (int it = 0; it < 40; it++) begin
            logic [DW-1:0] ac, ad, au, bc, bd, bu;
            ac = $urandom; ad = $urandom; au = $urandom;
            bc = $urandom; bd = $urandom; bu = $urandom;
            if (it == 0) begin
                for (int p = 0; p < NP; p++) begin
                    bc[2*p +: 2] = 2'(p % 4);
                    ac[2*p +: 2] = 2'(p / 4);
                end
            end else if (it == 1) bc = ac;
            else if (it == 2) begin ac = '1; bc = '0; end
            else if (it == 3) begin ac = '0; bc = {16{2'b01}}; end
            preset(ac, ad, au);
            do_save();
            chk(tr_n == 0, "R1 save writes nothing", 32'(tr_n), 32'd0);
            chk(err == 1'b0, "R11 err cleared by save", 32'(err), 32'd0);
            preset(bc, bd, bu);
            do_restore(ac, ad, au, bc, (it % 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule